// File: doc/BRIEF.md
# Stripe-Column Coding Pass Membership

This block sits in the bit-plane coding stage of a wavelet image coder. In one cycle it takes one stripe column: four vertically adjacent samples of the current bit-plane, along with the significance of the fourteen neighbours around them. It decides which of the four samples are coded in the current pass. The pass is chosen by a two-bit selector: significance propagation, magnitude refinement or cleanup. The block also produces two further results. One is the significance of the upper three samples as it stands after this column is coded. The other is an eight-bit neighbour significance set for each sample, which a later context-label stage consumes.

In the significance propagation pass, the flags ripple down the column. A sample can become significant higher up in the same column and the same pass. When that happens, the samples below it see that change and join the pass. This keeps the result correct without a second visit to the column. Every result is captured in a register on a cycle where `in_valid` is high. The results appear one cycle later with `out_valid`, and they hold steady while `in_valid` stays low.

Top module: `stripe_pass_sel`

## Requirements
- R1: While `rst` is high at a rising clock edge, `out_valid`, `flags`, `sig_upd` and `nbr_set` all become 0.
- R2: `out_valid` equals the `in_valid` sampled at the previous rising edge. The other outputs show the results for the inputs sampled at the most recent edge where `in_valid` was 1, and hold their value otherwise.
- R3: `pass_sel` is decoded as follows: 2'b00 selects significance propagation, 2'b01 selects magnitude refinement and 2'b10 selects cleanup. 2'b11 forces every flag to 0.
- R4: In significance propagation, sample r (0 = top) is flagged only when `sig_bits[r]` is 0 and one of three conditions holds: its out-of-column term is 1, the sample directly below it is significant, or sample r-1 is flagged and its data bit is 1. A significant sample is never flagged.
- R5: The out-of-column term of sample r is the OR of the left and right neighbour columns over rows r-1, r and r+1. Sample 0 also includes the centre location above the stripe. Bit layout: `nb_above`/`nb_below` bit 0 = left, 1 = centre, 2 = right; `nb_left[r]`/`nb_right[r]` = row r.
- R6: Sample 0 has no term from a sample above it. For sample 3, the sample below is `nb_below[1]`.
- R7: In magnitude refinement, sample r is flagged exactly when `sig_bits[r]` is 1 and `cs_bits[r]` is 0.
- R8: In cleanup, sample r is flagged exactly when `cs_bits[r]` is 0.
- R9: `sig_upd[r]` = `sig_bits[r]` OR (`flags[r]` AND `data_bits[r]`) for r = 0..2.
- R10: `nbr_set[8r+7:8r]` belongs to sample r. Its bits are: 0 up-left, 1 up, 2 up-right, 3 left, 4 right, 5 down-left, 6 down, 7 down-right. For r >= 1, the up bit is the updated significance of sample r-1.
- R11: In one significance propagation pass, a single outside neighbour of sample 0 can pull samples 1, 2 and 3 into the pass in turn, provided each sample above has data bit 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Column inputs are valid this cycle |
| pass_sel | input | 2 | Current coding pass |
| data_bits | input | 3 | Bit-plane data bits of samples 0..2 (sample 3's bit affects no output) |
| cs_bits | input | 4 | Already-coded-in-this-plane bits per sample |
| sig_bits | input | 4 | Significance of the four column samples |
| nb_above | input | 3 | Significance of the row above the stripe (left, centre, right) |
| nb_below | input | 3 | Significance of the row below the stripe (left, centre, right) |
| nb_left | input | 4 | Significance of the left neighbour column, per row |
| nb_right | input | 4 | Significance of the right neighbour column, per row |
| out_valid | output | 1 | Registered results valid |
| flags | output | 4 | Pass membership per sample |
| sig_upd | output | 3 | Updated significance of samples 0..2 |
| nbr_set | output | 32 | Eight-neighbour significance set per sample |

## Verification
Directed columns come first. A lone neighbour on each side of the window separates sample 0's extra centre term from the plain left/right row spans. A lone significant location below the stripe checks that it reaches only sample 3. Data patterns such as 111 and 101 set against a single seed show how far the ripple travels and where a zero data bit stops it. Every pass code is applied to the same state so that refinement, cleanup and the illegal code can be told apart. Random columns with idle gaps then stress the hold behaviour and the updated-significance term in the neighbour sets.

// File: rtl/spm_pkg.sv
package spm_pkg;

    typedef enum logic [1:0] {
        PASS_SPP = 2'b00,
        PASS_REF = 2'b01,
        PASS_CLN = 2'b10,
        PASS_BAD = 2'b11
    } pass_e;

    localparam int NSET_W = 8;

    localparam int NB_UL = 0;
    localparam int NB_UP = 1;
    localparam int NB_UR = 2;
    localparam int NB_LF = 3;
    localparam int NB_RT = 4;
    localparam int NB_DL = 5;
    localparam int NB_DN = 6;
    localparam int NB_DR = 7;

    typedef struct packed {
        logic l;
        logic c;
        logic r;
    } trio_t;

    typedef struct packed {
        logic l;
        logic r;
    } duo_t;

    function automatic logic [NSET_W-1:0] pack_nbr(input trio_t up, input duo_t mid, input trio_t dn);
        logic [NSET_W-1:0] v;
        v        = '0;
        v[NB_UL] = up.l;
        v[NB_UP] = up.c;
        v[NB_UR] = up.r;
        v[NB_LF] = mid.l;
        v[NB_RT] = mid.r;
        v[NB_DL] = dn.l;
        v[NB_DN] = dn.c;
        v[NB_DR] = dn.r;
        return v;
    endfunction

endpackage

// File: rtl/spm_window.sv
module spm_window #(
    parameter int ROWS = 4
) (
    input  logic [2:0]      nb_above,
    input  logic [2:0]      nb_below,
    input  logic [ROWS-1:0] nb_left,
    input  logic [ROWS-1:0] nb_right,
    output logic [ROWS+1:0] col_l,
    output logic [ROWS+1:0] col_r,
    output logic [ROWS-1:0] oc_any
);

    localparam int EXT = ROWS + 2;

    assign col_l[0]     = nb_above[0];
    assign col_r[0]     = nb_above[2];
    assign col_l[EXT-1] = nb_below[0];
    assign col_r[EXT-1] = nb_below[2];

    for (genvar k = 0; k < ROWS; k++) begin : g_side
        assign col_l[k+1] = nb_left[k];
        assign col_r[k+1] = nb_right[k];
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_oc
        logic span;
        assign span = (|col_l[r+2:r]) | (|col_r[r+2:r]);
        if (r == 0) begin : g_top
            assign oc_any[r] = span | nb_above[1];
        end else begin : g_rest
            assign oc_any[r] = span;
        end
    end

endmodule

// File: rtl/spm_flag_chain.sv
module spm_flag_chain
    import spm_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  pass_e           pass,
    input  logic [ROWS-2:0] data_bits,
    input  logic [ROWS-1:0] cs_bits,
    input  logic [ROWS-1:0] sig_bits,
    input  logic [ROWS-1:0] oc_any,
    input  logic            below_sig,
    output logic [ROWS-1:0] flags,
    output logic [ROWS-2:0] sig_new
);

    logic [ROWS-1:0] spp_f;
    logic [ROWS-1:0] push;
    logic [ROWS-1:0] under;

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        if (r == 0) begin : g_first
            assign push[r] = 1'b0;
        end else begin : g_next
            assign push[r] = spp_f[r-1] & data_bits[r-1];
        end
        if (r == ROWS - 1) begin : g_last
            assign under[r] = below_sig;
        end else begin : g_mid
            assign under[r] = sig_bits[r+1];
        end
        assign spp_f[r] = ~sig_bits[r] & (oc_any[r] | under[r] | push[r]);
    end

    always_comb begin
        unique case (pass)
            PASS_SPP: flags = spp_f;
            PASS_REF: flags = sig_bits & ~cs_bits;
            PASS_CLN: flags = ~cs_bits;
            default:  flags = '0;
        endcase
    end

    for (genvar r = 0; r < ROWS - 1; r++) begin : g_upd
        assign sig_new[r] = sig_bits[r] | (flags[r] & data_bits[r]);
    end

endmodule

// File: rtl/spm_nbr_gather.sv
module spm_nbr_gather
    import spm_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic [ROWS+1:0]        col_l,
    input  logic [ROWS+1:0]        col_r,
    input  logic                   above_c,
    input  logic                   below_c,
    input  logic [ROWS-1:1]        sig_lower,
    input  logic [ROWS-2:0]        sig_new,
    output logic [ROWS*NSET_W-1:0] sets
);

    for (genvar r = 0; r < ROWS; r++) begin : g_set
        trio_t up;
        duo_t  mid;
        trio_t dn;

        assign up.l  = col_l[r];
        assign up.r  = col_r[r];
        assign mid.l = col_l[r+1];
        assign mid.r = col_r[r+1];
        assign dn.l  = col_l[r+2];
        assign dn.r  = col_r[r+2];

        if (r == 0) begin : g_top
            assign up.c = above_c;
        end else begin : g_in
            assign up.c = sig_new[r-1];
        end

        if (r == ROWS - 1) begin : g_bot
            assign dn.c = below_c;
        end else begin : g_inner
            assign dn.c = sig_lower[r+1];
        end

        assign sets[r*NSET_W +: NSET_W] = pack_nbr(up, mid, dn);
    end

endmodule

// File: rtl/stripe_pass_sel.sv
module stripe_pass_sel
    import spm_pkg::*;
#(
    parameter int ROWS = 4
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   in_valid,
    input  logic [1:0]             pass_sel,
    input  logic [ROWS-2:0]        data_bits,
    input  logic [ROWS-1:0]        cs_bits,
    input  logic [ROWS-1:0]        sig_bits,
    input  logic [2:0]             nb_above,
    input  logic [2:0]             nb_below,
    input  logic [ROWS-1:0]        nb_left,
    input  logic [ROWS-1:0]        nb_right,
    output logic                   out_valid,
    output logic [ROWS-1:0]        flags,
    output logic [ROWS-2:0]        sig_upd,
    output logic [ROWS*NSET_W-1:0] nbr_set
);

    localparam int SET_BITS = ROWS * NSET_W;

    logic [ROWS+1:0]     col_l;
    logic [ROWS+1:0]     col_r;
    logic [ROWS-1:0]     oc_any;
    logic [ROWS-1:0]     flags_d;
    logic [ROWS-2:0]     sig_new;
    logic [SET_BITS-1:0] sets_d;
    pass_e               pass;

    assign pass = pass_e'(pass_sel);

    spm_window #(.ROWS(ROWS)) u_window (
        .nb_above (nb_above),
        .nb_below (nb_below),
        .nb_left  (nb_left),
        .nb_right (nb_right),
        .col_l    (col_l),
        .col_r    (col_r),
        .oc_any   (oc_any)
    );

    spm_flag_chain #(.ROWS(ROWS)) u_chain (
        .pass      (pass),
        .data_bits (data_bits),
        .cs_bits   (cs_bits),
        .sig_bits  (sig_bits),
        .oc_any    (oc_any),
        .below_sig (nb_below[1]),
        .flags     (flags_d),
        .sig_new   (sig_new)
    );

    spm_nbr_gather #(.ROWS(ROWS)) u_gather (
        .col_l     (col_l),
        .col_r     (col_r),
        .above_c   (nb_above[1]),
        .below_c   (nb_below[1]),
        .sig_lower (sig_bits[ROWS-1:1]),
        .sig_new   (sig_new),
        .sets      (sets_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            flags     <= '0;
            sig_upd   <= '0;
            nbr_set   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                flags   <= flags_d;
                sig_upd <= sig_new;
                nbr_set <= sets_d;
            end
        end
    end

endmodule

// File: rtl/spm_pass_chk.sv
module spm_pass_chk #(
    parameter int ROWS = 4
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [1:0]      pass_sel,
    input logic [ROWS-2:0] data_bits,
    input logic [ROWS-1:0] cs_bits,
    input logic [ROWS-1:0] sig_bits,
    input logic            up_c,
    input logic            out_valid,
    input logic [ROWS-1:0] flags,
    input logic [ROWS-2:0] sig_upd,
    input logic            nbr_up0
);

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);  // R2

    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);  // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(flags) && $stable(sig_upd)));  // R2

    AST_BAD_PASS_NONE: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pass_sel == 2'b11) |=> (flags == '0));  // R3

    AST_SPP_SKIPS_SIG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pass_sel == 2'b00) |=> ((flags & $past(sig_bits)) == '0));  // R4

    AST_REF_MEMBERS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pass_sel == 2'b01) |=> (flags == ($past(sig_bits) & ~$past(cs_bits))));  // R7

    AST_CLN_MEMBERS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && pass_sel == 2'b10) |=> (flags == ~$past(cs_bits)));  // R8

    AST_SIG_GROWS: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (sig_upd == ($past(sig_bits[ROWS-2:0]) | (flags[ROWS-2:0] & $past(data_bits)))));  // R9

    AST_TOP_UP_BIT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (nbr_up0 == $past(up_c)));  // R10

endmodule

bind stripe_pass_sel spm_pass_chk #(.ROWS(ROWS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .pass_sel  (pass_sel),
    .data_bits (data_bits),
    .cs_bits   (cs_bits),
    .sig_bits  (sig_bits),
    .up_c      (nb_above[1]),
    .out_valid (out_valid),
    .flags     (flags),
    .sig_upd   (sig_upd),
    .nbr_up0   (nbr_set[1])
);

// File: tb/test_stripe_pass_sel.sv
`timescale 1ns/1ps
module test_stripe_pass_sel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  pass_sel = 2'b00;
    logic [2:0]  data_bits = '0;
    logic [3:0]  cs_bits = '0;
    logic [3:0]  sig_bits = '0;
    logic [2:0]  nb_above = '0;
    logic [2:0]  nb_below = '0;
    logic [3:0]  nb_left = '0;
    logic [3:0]  nb_right = '0;
    logic        out_valid;
    logic [3:0]  flags;
    logic [2:0]  sig_upd;
    logic [31:0] nbr_set;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic        e_valid = 1'b0;
    logic [3:0]  e_flags = '0;
    logic [2:0]  e_sig = '0;
    logic [31:0] e_nbr = '0;

    always #2 clk = ~clk;

    stripe_pass_sel i_stripe_pass_sel (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .pass_sel  (pass_sel),
        .data_bits (data_bits),
        .cs_bits   (cs_bits),
        .sig_bits  (sig_bits),
        .nb_above  (nb_above),
        .nb_below  (nb_below),
        .nb_left   (nb_left),
        .nb_right  (nb_right),
        .out_valid (out_valid),
        .flags     (flags),
        .sig_upd   (sig_upd),
        .nbr_set   (nbr_set)
    );

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // behavioural model: window grid w[row][col], rows 0 above .. 5 below, cols 0 left 1 centre 2 right
    task automatic model(input logic [1:0] ps, input logic [2:0] d, input logic [3:0] cs,
                         input logic [3:0] sg, input logic [2:0] ab, input logic [2:0] bl,
                         input logic [3:0] lf, input logic [3:0] rt);
        int w[6][3];
        int f[4];
        int ns[4];
        w[0][0] = int'(ab[0]); w[0][1] = int'(ab[1]); w[0][2] = int'(ab[2]);
        w[5][0] = int'(bl[0]); w[5][1] = int'(bl[1]); w[5][2] = int'(bl[2]);
        for (int k = 0; k < 4; k++) begin
            w[k+1][0] = int'(lf[k]);
            w[k+1][1] = int'(sg[k]);
            w[k+1][2] = int'(rt[k]);
        end
        for (int r = 0; r < 4; r++) begin
            int oc;
            int carry;
            oc = 0;
            for (int dr = 0; dr < 3; dr++) begin
                if (w[r+dr][0] != 0 || w[r+dr][2] != 0) oc = 1;
            end
            if (r == 0 && w[0][1] != 0) oc = 1;
            carry = (r > 0) ? ((f[r-1] != 0 && d[r-1]) ? 1 : 0) : 0;
            case (ps)
                2'b00:   f[r] = (w[r+1][1] == 0 && (oc != 0 || w[r+2][1] != 0 || carry != 0)) ? 1 : 0;
                2'b01:   f[r] = (w[r+1][1] != 0 && !cs[r]) ? 1 : 0;
                2'b10:   f[r] = cs[r] ? 0 : 1;
                default: f[r] = 0;
            endcase
            ns[r] = (w[r+1][1] != 0 || (r < 3 && f[r] != 0 && d[r])) ? 1 : 0;
        end
        for (int r = 0; r < 4; r++) begin
            e_flags[r] = (f[r] != 0);
            if (r < 3) e_sig[r] = (ns[r] != 0);
            e_nbr[8*r+0] = (w[r][0] != 0);
            e_nbr[8*r+1] = (r == 0) ? (w[0][1] != 0) : (ns[r-1] != 0);
            e_nbr[8*r+2] = (w[r][2] != 0);
            e_nbr[8*r+3] = (w[r+1][0] != 0);
            e_nbr[8*r+4] = (w[r+1][2] != 0);
            e_nbr[8*r+5] = (w[r+2][0] != 0);
            e_nbr[8*r+6] = (w[r+2][1] != 0);
            e_nbr[8*r+7] = (w[r+2][2] != 0);
        end
    endtask

    task automatic apply(input logic v, input logic [1:0] ps, input logic [2:0] d, input logic [3:0] cs,
                         input logic [3:0] sg, input logic [2:0] ab, input logic [2:0] bl,
                         input logic [3:0] lf, input logic [3:0] rt, input string tag);
        string ftag;
        in_valid  = v;
        pass_sel  = ps;
        data_bits = d;
        cs_bits   = cs;
        sig_bits  = sg;
        nb_above  = ab;
        nb_below  = bl;
        nb_left   = lf;
        nb_right  = rt;
        if (v) model(ps, d, cs, sg, ab, bl, lf, rt);
        e_valid = v;
        @(posedge clk);
        @(negedge clk);
        if (tag != "") ftag = tag;
        else if (!v) ftag = "R2";
        else case (ps)
            2'b00:   ftag = "R4";
            2'b01:   ftag = "R7";
            2'b10:   ftag = "R8";
            default: ftag = "R3";
        endcase
        check("R2", "out_valid", {31'd0, out_valid}, {31'd0, e_valid});
        check(ftag, "flags", {28'd0, flags}, {28'd0, e_flags});
        check(v ? "R9" : "R2", "sig_upd", {29'd0, sig_upd}, {29'd0, e_sig});
        check(v ? "R10" : "R2", "nbr_set", nbr_set, e_nbr);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state at the ports
        check("R1", "out_valid", {31'd0, out_valid}, 32'd0);
        check("R1", "flags", {28'd0, flags}, 32'd0);
        check("R1", "sig_upd", {29'd0, sig_upd}, 32'd0);
        check("R1", "nbr_set", nbr_set, 32'd0);

        // R5: lone neighbours on each side
        apply(1, 2'b00, 3'b000, 4'h0, 4'h0, 3'b010, 3'b000, 4'h0, 4'h0, "R5");
        apply(1, 2'b00, 3'b000, 4'h0, 4'h0, 3'b001, 3'b000, 4'h0, 4'h0, "R5");
        apply(1, 2'b00, 3'b000, 4'h0, 4'h0, 3'b000, 3'b000, 4'b0100, 4'h0, "R5");
        apply(1, 2'b00, 3'b000, 4'h0, 4'h0, 3'b000, 3'b100, 4'h0, 4'h0, "R5");
        apply(1, 2'b00, 3'b000, 4'h0, 4'h0, 3'b000, 3'b000, 4'h0, 4'b0001, "R5");
        // R6: location below the stripe reaches only sample 3
        apply(1, 2'b00, 3'b111, 4'h0, 4'h0, 3'b000, 3'b010, 4'h0, 4'h0, "R6");
        // R11: ripple from a single seed, full and broken
        apply(1, 2'b00, 3'b111, 4'h0, 4'h0, 3'b001, 3'b000, 4'h0, 4'h0, "R11");
        apply(1, 2'b00, 3'b101, 4'h0, 4'h0, 3'b001, 3'b000, 4'h0, 4'h0, "R11");
        apply(1, 2'b00, 3'b011, 4'h0, 4'b0001, 3'b000, 3'b000, 4'h0, 4'h0, "R11");
        // R4: significant samples skipped, below term
        apply(1, 2'b00, 3'b111, 4'h0, 4'b1010, 3'b000, 3'b000, 4'h0, 4'h0, "R4");
        // pass codes on the same state
        apply(1, 2'b01, 3'b110, 4'b0011, 4'b0110, 3'b010, 3'b000, 4'h0, 4'h0, "R7");
        apply(1, 2'b10, 3'b110, 4'b0011, 4'b0110, 3'b010, 3'b000, 4'h0, 4'h0, "R8");
        apply(1, 2'b11, 3'b110, 4'b0011, 4'b0110, 3'b010, 3'b111, 4'hF, 4'hF, "R3");
        // R2: idle cycles hold the last result
        apply(1, 2'b10, 3'b111, 4'b0000, 4'b0000, 3'b000, 3'b000, 4'h0, 4'h0, "R8");
        apply(0, 2'b01, 3'b000, 4'hF, 4'hF, 3'b111, 3'b111, 4'hF, 4'hF, "R2");
        apply(0, 2'b11, 3'b010, 4'h0, 4'h5, 3'b101, 3'b010, 4'hA, 4'h5, "R2");

        for (int i = 0; i < 600; i++) begin
            logic [31:0] rv;
            rv = $urandom;
            apply((rv[1:0] != 2'b00), rv[3:2], rv[6:4], rv[10:7], rv[14:11] & rv[18:15],
                  rv[21:19] & rv[24:22], rv[27:25], rv[31:28] & rv[3:0], rv[7:4] & rv[11:8], "");
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule